// File: doc/BRIEF.md
# Extended Address Effective-Address Generator

This block forms 20-bit effective addresses for a 16-bit processor. Each index register (X, Y, Z) and the program counter carry a 4-bit extension field. Every address is built on the 20-bit value {extension, register}, and every sum wraps modulo 2^20. A carry out of the low 16 bits, or a borrow into them, therefore changes the extension field. The modes differ in how they widen the offset: a signed 16-bit offset, a full 20-bit offset, sign-extended accumulator E, or a signed 8-bit or 16-bit branch displacement. In post-modified mode, the unmodified X pair is the address and X is rewritten one cycle later.

A request is accepted by a `start` pulse while the block is idle. The operands are captured on that clock edge. The result is presented in the next cycle, marked by `done`. The block is a three-state machine:

- `ST_IDLE` waits for `start` and captures the operands, then moves to `ST_EVAL`.
- `ST_EVAL` presents the result. It moves to `ST_WBACK` for a valid post-modified request and returns to `ST_IDLE` otherwise.
- `ST_WBACK` pulses the index write-back, then returns to `ST_IDLE`.

Top module: `eag_top`

## Requirements
- R1: While reset is asserted, `busy`, `done`, `ea_valid`, `err`, `pc_we` and `idx_we` are all 0.
- R2: Mode 3'd0 (16-bit indexed) gives `ea` = {ext,reg} + sign-extended `offset[15:0]`. The register is selected by `idx_sel`: 2'b00 selects X, 2'b01 selects Y and 2'b10 selects Z.
- R3: Mode 3'd1 (20-bit indexed) gives `ea` = {ext,reg} + `offset[19:0]` for the register selected by `idx_sel`.
- R4: Mode 3'd2 (accumulator offset) gives `ea` = {ext,reg} + sign-extended `acc_e`.
- R5: Mode 3'd3 (short branch) and mode 3'd4 (long branch) with `taken`=1 give `ea` = {pk,pc} + sign-extended `offset[7:0]` or `offset[15:0]` respectively, with `pc_we`=1.
- R6: A branch mode with `taken`=0 gives `ea` = {pk,pc} unchanged, with `ea_valid`=1 and `pc_we`=0.
- R7: Mode 3'd5 (post-modified) gives `ea` = {xk,ix} with `idx_we`=0 in the result cycle. In the following cycle it gives exactly one pulse of `idx_we` with `idx_wsel`=2'b00 and {`idx_wext`,`idx_wdata`} = {xk,ix} + sign-extended `offset[7:0]`. `idx_sel` has no effect in this mode.
- R8: Mode 3'd6 (inherent) gives `done`=1 with `ea_valid`=0, `err`=0 and `pc_we`=0.
- R9: `idx_sel`=2'b11 in modes 3'd0 to 3'd2, or mode 3'd7, gives `err`=1 with `ea_valid`=0, `pc_we`=0 and no write-back.
- R10: The result appears with `done` high for exactly one cycle, in the cycle after `start` is sampled in `ST_IDLE`. A `start` seen while `busy` is ignored.
- R11: All sums wrap modulo 2^20. A carry or borrow across bit 16 updates the extension bits `ea[19:16]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled when idle |
| mode | input | 3 | Addressing mode code |
| idx_sel | input | 2 | Index register select |
| ix | input | 16 | Index register X |
| iy | input | 16 | Index register Y |
| iz | input | 16 | Index register Z |
| xk | input | 4 | Extension of X |
| yk | input | 4 | Extension of Y |
| zk | input | 4 | Extension of Z |
| acc_e | input | 16 | Accumulator E |
| pk | input | 4 | Program counter extension |
| pc | input | 16 | Program counter |
| offset | input | 20 | Instruction offset field |
| taken | input | 1 | Branch condition is true |
| busy | output | 1 | Request in progress |
| done | output | 1 | Result cycle |
| ea_valid | output | 1 | `ea` holds an address |
| ea | output | 20 | Effective address, or new {pk,pc} for branches |
| err | output | 1 | Invalid select or reserved mode |
| pc_we | output | 1 | Branch taken: load `ea` into {pk,pc} |
| idx_we | output | 1 | Index write-back strobe |
| idx_wsel | output | 2 | Index register to write |
| idx_wdata | output | 16 | New index register value |
| idx_wext | output | 4 | New index extension value |

## Verification
The assertions check the timing contract on every cycle:
- `done` is a single-cycle pulse that follows an accepted `start`.
- A write-back pulse only ever follows a valid result and never repeats.
- An error never coincides with a valid address or a program counter load.
- `pc_we` only appears with a valid result.

The address arithmetic itself can only be shown by the bench's scenarios. These cover carries and borrows into the extension, wrap at 2^20, the sign of each offset width, untaken branches, an ignored select in post-modified mode, and a `start` held high through a busy request.

// File: rtl/eag_pkg.sv
package eag_pkg;

    typedef enum logic [2:0] {
        M_IDX16 = 3'd0,
        M_IDX20 = 3'd1,
        M_ACCE  = 3'd2,
        M_REL8  = 3'd3,
        M_REL16 = 3'd4,
        M_POST  = 3'd5,
        M_INH   = 3'd6,
        M_RSV   = 3'd7
    } eag_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVAL  = 2'd1,
        ST_WBACK = 2'd2
    } eag_state_e;

    localparam logic [1:0] SEL_X   = 2'b00;
    localparam logic [1:0] SEL_Y   = 2'b01;
    localparam logic [1:0] SEL_Z   = 2'b10;
    localparam logic [1:0] SEL_BAD = 2'b11;

endpackage

// File: rtl/eag_base_sel.sv
module eag_base_sel
    import eag_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int EXT_W = 4
) (
    input  logic [2:0]             mode,
    input  logic [1:0]             idx_sel,
    input  logic [REG_W-1:0]       ix,
    input  logic [REG_W-1:0]       iy,
    input  logic [REG_W-1:0]       iz,
    input  logic [EXT_W-1:0]       xk,
    input  logic [EXT_W-1:0]       yk,
    input  logic [EXT_W-1:0]       zk,
    input  logic [EXT_W-1:0]       pk,
    input  logic [REG_W-1:0]       pc,
    output logic [REG_W+EXT_W-1:0] base,
    output logic                   bad_sel
);
    localparam int AW = REG_W + EXT_W;

    logic [AW-1:0] idx_base;
    logic          uses_sel;

    always_comb begin
        unique case (idx_sel)
            SEL_X:   idx_base = {xk, ix};
            SEL_Y:   idx_base = {yk, iy};
            SEL_Z:   idx_base = {zk, iz};
            default: idx_base = '0;
        endcase
    end

    always_comb begin
        uses_sel = 1'b0;
        unique case (eag_mode_e'(mode))
            M_REL8, M_REL16: base = {pk, pc};
            M_POST:          base = {xk, ix};
            M_IDX16, M_IDX20, M_ACCE: begin
                base     = idx_base;
                uses_sel = 1'b1;
            end
            default:         base = '0;
        endcase
    end

    assign bad_sel = uses_sel && (idx_sel == SEL_BAD);

endmodule

// File: rtl/eag_off_ext.sv
module eag_off_ext
    import eag_pkg::*;
#(
    parameter int REG_W   = 16,
    parameter int EXT_W   = 4,
    parameter int SHORT_W = 8
) (
    input  logic [2:0]             mode,
    input  logic [REG_W+EXT_W-1:0] offset,
    input  logic [REG_W-1:0]       acc_e,
    output logic [REG_W+EXT_W-1:0] off_ext
);
    localparam int AW = REG_W + EXT_W;

    logic [AW-1:0] sx_long;
    logic [AW-1:0] sx_short;
    logic [AW-1:0] sx_acc;

    assign sx_long  = {{(AW-REG_W){offset[REG_W-1]}}, offset[REG_W-1:0]};
    assign sx_short = {{(AW-SHORT_W){offset[SHORT_W-1]}}, offset[SHORT_W-1:0]};
    assign sx_acc   = {{(AW-REG_W){acc_e[REG_W-1]}}, acc_e};

    always_comb begin
        unique case (eag_mode_e'(mode))
            M_IDX16, M_REL16: off_ext = sx_long;
            M_IDX20:          off_ext = offset;
            M_ACCE:           off_ext = sx_acc;
            M_REL8, M_POST:   off_ext = sx_short;
            default:          off_ext = '0;
        endcase
    end

endmodule

// File: rtl/eag_top.sv
module eag_top
    import eag_pkg::*;
#(
    parameter int REG_W   = 16,
    parameter int EXT_W   = 4,
    parameter int SHORT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [2:0]             mode,
    input  logic [1:0]             idx_sel,
    input  logic [REG_W-1:0]       ix,
    input  logic [REG_W-1:0]       iy,
    input  logic [REG_W-1:0]       iz,
    input  logic [EXT_W-1:0]       xk,
    input  logic [EXT_W-1:0]       yk,
    input  logic [EXT_W-1:0]       zk,
    input  logic [REG_W-1:0]       acc_e,
    input  logic [EXT_W-1:0]       pk,
    input  logic [REG_W-1:0]       pc,
    input  logic [REG_W+EXT_W-1:0] offset,
    input  logic                   taken,
    output logic                   busy,
    output logic                   done,
    output logic                   ea_valid,
    output logic [REG_W+EXT_W-1:0] ea,
    output logic                   err,
    output logic                   pc_we,
    output logic                   idx_we,
    output logic [1:0]             idx_wsel,
    output logic [REG_W-1:0]       idx_wdata,
    output logic [EXT_W-1:0]       idx_wext
);
    localparam int AW = REG_W + EXT_W;

    eag_state_e    state, state_nx;
    eag_mode_e     mode_q;
    logic [AW-1:0] base_d, base_q;
    logic [AW-1:0] off_d, off_q;
    logic          bad_d, bad_q;
    logic          taken_q;
    logic [AW-1:0] sum;
    logic          accept;

    eag_base_sel #(.REG_W(REG_W), .EXT_W(EXT_W)) u_base (
        .mode(mode), .idx_sel(idx_sel),
        .ix(ix), .iy(iy), .iz(iz),
        .xk(xk), .yk(yk), .zk(zk),
        .pk(pk), .pc(pc),
        .base(base_d), .bad_sel(bad_d)
    );

    eag_off_ext #(.REG_W(REG_W), .EXT_W(EXT_W), .SHORT_W(SHORT_W)) u_off (
        .mode(mode), .offset(offset), .acc_e(acc_e), .off_ext(off_d)
    );

    assign accept = (state == ST_IDLE) && start;
    assign sum    = base_q + off_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= M_INH;
            base_q  <= '0;
            off_q   <= '0;
            bad_q   <= 1'b0;
            taken_q <= 1'b0;
        end else if (accept) begin
            mode_q  <= eag_mode_e'(mode);
            base_q  <= base_d;
            off_q   <= off_d;
            bad_q   <= bad_d;
            taken_q <= taken;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_EVAL;
            ST_EVAL:  state_nx = (mode_q == M_POST) ? ST_WBACK : ST_IDLE;
            ST_WBACK: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        done      = 1'b0;
        ea_valid  = 1'b0;
        ea        = '0;
        err       = 1'b0;
        pc_we     = 1'b0;
        idx_we    = 1'b0;
        idx_wsel  = SEL_X;
        idx_wdata = '0;
        idx_wext  = '0;
        unique case (state)
            ST_IDLE: ;
            ST_EVAL: begin
                done = 1'b1;
                unique case (mode_q)
                    M_IDX16, M_IDX20, M_ACCE: begin
                        err      = bad_q;
                        ea_valid = !bad_q;
                        ea       = bad_q ? '0 : sum;
                    end
                    M_REL8, M_REL16: begin
                        ea_valid = 1'b1;
                        ea       = taken_q ? sum : base_q;
                        pc_we    = taken_q;
                    end
                    M_POST: begin
                        ea_valid = 1'b1;
                        ea       = base_q;
                    end
                    M_INH: ;
                    M_RSV: err = 1'b1;
                    default: err = 1'b1;
                endcase
            end
            ST_WBACK: begin
                idx_we                = 1'b1;
                idx_wsel              = SEL_X;
                {idx_wext, idx_wdata} = sum;
            end
            default: ;
        endcase
    end

    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/eag_chk.sv
module eag_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic ea_valid,
    input logic err,
    input logic pc_we,
    input logic idx_we
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_START_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> done); // R10
    AST_RESULT_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_valid || err || pc_we) |-> done); // R10
    AST_WB_AFTER_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        idx_we |-> $past(done && ea_valid && !err)); // R7
    AST_WB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        idx_we |=> !idx_we); // R7
    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!ea_valid && !pc_we)); // R9
    AST_PC_WE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |-> ea_valid); // R5
endmodule

bind eag_top eag_chk u_chk (.*);

// File: tb/sim_eag_top.sv
module sim_eag_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  idx_sel = '0;
    logic [15:0] ix = 16'hFFF0, iy = 16'h0008, iz = 16'h1234;
    logic [3:0]  xk = 4'h3, yk = 4'h5, zk = 4'hF;
    logic [15:0] acc_e = 16'h8000;
    logic [3:0]  pk = 4'h2;
    logic [15:0] pc = 16'hFFFE;
    logic [19:0] offset = '0;
    logic        taken = 1'b0;
    logic        busy, done, ea_valid, err, pc_we, idx_we;
    logic [19:0] ea;
    logic [1:0]  idx_wsel;
    logic [15:0] idx_wdata;
    logic [3:0]  idx_wext;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        bit          v;
        bit          e;
        bit          p;
        logic [19:0] a;
        string       tag;
    } res_t;
    typedef struct {
        logic [19:0] val;
        string       tag;
    } wb_t;

    res_t rq[$];
    wb_t  wq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    eag_top u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .idx_sel(idx_sel),
        .ix(ix), .iy(iy), .iz(iz), .xk(xk), .yk(yk), .zk(zk),
        .acc_e(acc_e), .pk(pk), .pc(pc), .offset(offset), .taken(taken),
        .busy(busy), .done(done), .ea_valid(ea_valid), .ea(ea), .err(err),
        .pc_we(pc_we), .idx_we(idx_we), .idx_wsel(idx_wsel),
        .idx_wdata(idx_wdata), .idx_wext(idx_wext)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] sx16(input logic [15:0] v);
        return {{4{v[15]}}, v};
    endfunction
    function automatic logic [19:0] sx8(input logic [7:0] v);
        return {{12{v[7]}}, v};
    endfunction

    // driver: computes the expected result from the requirements and pushes it
    task automatic push_expect(input logic [2:0] m, input logic [1:0] s, input logic [19:0] off,
                               input bit tk, input string tag);
        res_t r;
        wb_t  w;
        logic [19:0] b;
        b = (s == 2'd0) ? {xk, ix} : (s == 2'd1) ? {yk, iy} : {zk, iz};
        r.v = 0; r.e = 0; r.p = 0; r.a = '0; r.tag = tag;
        case (m)
            3'd0, 3'd1, 3'd2: begin
                if (s == 2'b11) r.e = 1;
                else begin
                    r.v = 1;
                    r.a = b + ((m == 3'd0) ? sx16(off[15:0]) : (m == 3'd1) ? off : sx16(acc_e));
                end
            end
            3'd3, 3'd4: begin
                r.v = 1;
                r.p = tk;
                r.a = tk ? ({pk, pc} + ((m == 3'd3) ? sx8(off[7:0]) : sx16(off[15:0]))) : {pk, pc};
            end
            3'd5: begin
                r.v = 1;
                r.a = {xk, ix};
                w.val = {xk, ix} + sx8(off[7:0]);
                w.tag = tag;
                wq.push_back(w);
            end
            3'd6: ;
            default: r.e = 1;
        endcase
        rq.push_back(r);
    endtask

    task automatic issue(input logic [2:0] m, input logic [1:0] s, input logic [19:0] off,
                         input bit tk, input string tag);
        @(negedge clk);
        mode = m; idx_sel = s; offset = off; taken = tk;
        push_expect(m, s, off, tk, tag);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (done) begin
                if (rq.size() == 0) check(1'b0, "R10 unexpected done", 1, 0);
                else begin
                    res_t r;
                    r = rq.pop_front();
                    check(ea_valid == r.v, {r.tag, " ea_valid"}, ea_valid, r.v);
                    check(err == r.e, {r.tag, " err"}, err, r.e);
                    check(pc_we == r.p, {r.tag, " pc_we"}, pc_we, r.p);
                    check(idx_we == 1'b0, {r.tag, " R7 no write in result cycle"}, idx_we, 0);
                    if (r.v) check(ea == r.a, {r.tag, " ea"}, ea, r.a);
                end
            end
            if (idx_we) begin
                if (wq.size() == 0) check(1'b0, "R7 unexpected idx_we", 1, 0);
                else begin
                    wb_t w;
                    w = wq.pop_front();
                    check({idx_wext, idx_wdata} == w.val, {w.tag, " R7 write-back value"},
                          {idx_wext, idx_wdata}, w.val);
                    check(idx_wsel == 2'b00, {w.tag, " R7 write-back target"}, idx_wsel, 0);
                end
            end
        end
    end

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({busy, done, ea_valid, err, pc_we, idx_we} == 6'b0, "R1 reset outputs",
              {busy, done, ea_valid, err, pc_we, idx_we}, 0);
        rst_n = 1'b1;

        issue(3'd0, 2'b00, 20'h00020, 0, "R2 R11 X carry");
        issue(3'd0, 2'b01, 20'h0FFF0, 0, "R2 R11 Y borrow");
        issue(3'd0, 2'b10, 20'h07000, 0, "R2 Z");
        issue(3'd1, 2'b00, 20'h00010, 0, "R3 X");
        issue(3'd1, 2'b10, 20'h10000, 0, "R3 R11 Z wrap");
        issue(3'd2, 2'b01, 20'h0, 0, "R4 Y negative E");
        acc_e = 16'h0100;
        issue(3'd2, 2'b00, 20'h0, 0, "R4 X positive E");
        issue(3'd3, 2'b00, 20'h00004, 1, "R5 short fwd");
        issue(3'd3, 2'b00, 20'h000FE, 1, "R5 short back");
        issue(3'd4, 2'b00, 20'h08000, 1, "R5 long back");
        issue(3'd3, 2'b00, 20'h00004, 0, "R6 short not taken");
        issue(3'd4, 2'b00, 20'h01234, 0, "R6 long not taken");
        issue(3'd5, 2'b11, 20'h00080, 0, "R7 post negative sel ignored");
        issue(3'd5, 2'b01, 20'h0007F, 0, "R7 R11 post carry");
        issue(3'd6, 2'b00, 20'h0, 0, "R8 inherent");
        issue(3'd0, 2'b11, 20'h1, 0, "R9 idx16 bad sel");
        issue(3'd2, 2'b11, 20'h0, 0, "R9 acc bad sel");
        issue(3'd7, 2'b00, 20'h0, 0, "R9 reserved mode");

        // R10: start held high through a busy post-modified request
        @(negedge clk);
        mode = 3'd5; idx_sel = 2'b00; offset = 20'h00002;
        push_expect(3'd5, 2'b00, 20'h00002, 0, "R10 busy hold");
        start = 1'b1;
        @(negedge clk);
        check(busy == 1'b1, "R10 busy in result cycle", busy, 1);
        mode = 3'd0;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R10 idle after request", busy, 0);

        check(rq.size() == 0, "R10 all results seen", rq.size(), 0);
        check(wq.size() == 0, "R7 all write-backs seen", wq.size(), 0);
        finished = 1'b1;
        summary();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            check(1'b0, "watchdog expired", 0, 1);
            summary();
        end
    end

endmodule